// File: doc/BRIEF.md
# Priority Memory Bank Lock Arbiter

This block decides which requester may use each of a set of shared memory banks. Requesters are cores and coprocessors. A requester names one bank and raises its request line. Once it owns that bank, it keeps the bank for a whole multi-cycle operation until it sends an unlock pulse that names the same bank. While a bank is owned, every other requester that asks for it is told to wait. The bank cannot be taken away from its owner. When the owner releases it, the bank goes to the waiting requester with the highest static signed priority, and that hand-over happens at the same clock edge as the release.

Each bank has its own lock, so requesters on different banks never interfere. One requester may own several banks at the same time. It keeps a bank after it stops requesting it and moves its request to another bank, and it gives that bank up only with an explicit unlock. All inputs are sampled on a rising edge. The grant and wait outputs are registered and show the outcome of that edge.

Top module: `bank_lock_arbiter`

## Requirements
- R1: While reset is high and at the first edge after it, no bank is owned, and every grant_o and wait_o bit is low.
- R2: At no time are two requesters granted while they request the same bank.
- R3: A request to an unowned bank is granted at the edge that samples it, so grant_o is high in the following cycle.
- R4: A requesting requester shows exactly one of grant_o and wait_o high, and wait_o is high only while another requester owns the bank. A requester that is not requesting shows both low.
- R5: On release, the bank goes to the waiting requester with the largest signed priority. With the default priorities, requesters 0 to 7 have priorities 0 to 7, requester 8 has -2 and requester 9 has 3.
- R6: Among waiting requesters with equal priority, the one with the lower index wins.
- R7: When the owner unlocks a bank at the same edge at which others request it, the winner is granted at that edge, with no idle cycle between owners.
- R8: A request that arrives while the bank is owned does not displace the owner, whatever its priority.
- R9: An unlock pulse from a requester that does not own the named bank has no effect.
- R10: Banks are locked independently. One requester may own several banks, and a bank stays owned after its owner stops requesting it, until that owner unlocks it.
- R11: A requester that asks again for a bank it already owns is granted at once, even while others wait for that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | N_REQ | Per-requester request line |
| req_bank_i | input | N_REQ*BANK_W | Requested bank index for each requester; requester i uses bits [i*BANK_W +: BANK_W] |
| unlock_i | input | N_REQ | Per-requester one-cycle release pulse |
| unlock_bank_i | input | N_REQ*BANK_W | Bank index that each requester's unlock pulse releases, packed the same way as req_bank_i |
| grant_o | output | N_REQ | Requester owns the bank it requested at the last edge |
| wait_o | output | N_REQ | Requester asked for a bank that another requester owns |

## Verification
Directed sequences put five requesters on one bank with mixed priorities. These sequences separate a signed comparison from an unsigned one, since requester 8 has priority -2. They separate strict priority from first-come order, and the tie between requesters 3 and 9 shows which index a tie resolves to. Other sequences release the bank and request it at the same edge, or send an unlock from a requester that does not own the bank, or move a request away from a bank the requester still owns. These sequences separate a same-edge hand-over from one delayed by a cycle, and an owner-checked unlock from an unchecked one. A final random phase crowds ten requesters onto three banks, with frequent unlocks from owners and from non-owners. It compares every output against the behavioural model on every clock.

// File: rtl/bank_lock_pkg.sv
package bank_lock_pkg;
  localparam int PRIO_W = 16;
  typedef logic signed [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/bank_prio_pick.sv
module bank_prio_pick
  import bank_lock_pkg::*;
#(
  parameter int N_REQ = 10,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  parameter logic [N_REQ*PRIO_W-1:0] PRIO_VEC = '0
) (
  input  logic [N_REQ-1:0] cand_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // Ascending scan with a strict compare: on equal priority the lower index stays.
  always_comb begin
    prio_t best;
    prio_t cur;
    any_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      cur = PRIO_VEC[i*PRIO_W +: PRIO_W];
      if (cand_i[i] && (!any_o || cur > best)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = cur;
      end
    end
  end
endmodule

// File: rtl/bank_lock_slot.sv
module bank_lock_slot
  import bank_lock_pkg::*;
#(
  parameter int N_REQ   = 10,
  parameter int BANK_W  = 4,
  parameter int IDX_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  parameter int BANK_ID = 0,
  parameter logic [N_REQ*PRIO_W-1:0] PRIO_VEC = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_REQ-1:0]        req_valid_i,
  input  logic [N_REQ*BANK_W-1:0] req_bank_i,
  input  logic [N_REQ-1:0]        unlock_i,
  input  logic [N_REQ*BANK_W-1:0] unlock_bank_i,
  output logic                    held_d_o,
  output logic [IDX_W-1:0]        owner_d_o
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic             held_q;
  logic [IDX_W-1:0] owner_q;
  logic [N_REQ-1:0] cand;
  logic             release_now;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    release_now = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      cand[i] = req_valid_i[i] && (req_bank_i[i*BANK_W +: BANK_W] == MY_BANK);
      if (held_q && owner_q == IDX_W'(i) && unlock_i[i] &&
          unlock_bank_i[i*BANK_W +: BANK_W] == MY_BANK)
        release_now = 1'b1;
    end
  end

  bank_prio_pick #(
    .N_REQ(N_REQ), .IDX_W(IDX_W), .PRIO_VEC(PRIO_VEC)
  ) pick_i (
    .cand_i(cand), .any_o(pick_any), .idx_o(pick_idx)
  );

  // Arbitration only happens when the bank is free after this edge's release.
  always_comb begin
    if (!held_q || release_now) begin
      held_d_o  = pick_any;
      owner_d_o = pick_idx;
    end else begin
      held_d_o  = held_q;
      owner_d_o = owner_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      held_q  <= held_d_o;
      owner_q <= owner_d_o;
    end
  end
endmodule

// File: rtl/bank_lock_arbiter.sv
module bank_lock_arbiter
  import bank_lock_pkg::*;
#(
  parameter int N_REQ  = 10,
  parameter int N_BANK = 16,
  parameter int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  parameter logic [N_REQ*PRIO_W-1:0] PRIO_VEC = {
    16'sd3, -16'sd2, 16'sd7, 16'sd6, 16'sd5,
    16'sd4, 16'sd3, 16'sd2, 16'sd1, 16'sd0}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_REQ-1:0]        req_valid_i,
  input  logic [N_REQ*BANK_W-1:0] req_bank_i,
  input  logic [N_REQ-1:0]        unlock_i,
  input  logic [N_REQ*BANK_W-1:0] unlock_bank_i,
  output logic [N_REQ-1:0]        grant_o,
  output logic [N_REQ-1:0]        wait_o
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_BANK-1:0] held_d;
  logic [IDX_W-1:0]  owner_d [N_BANK];
  logic [N_REQ-1:0]  grant_d;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    bank_lock_slot #(
      .N_REQ(N_REQ), .BANK_W(BANK_W), .IDX_W(IDX_W),
      .BANK_ID(b), .PRIO_VEC(PRIO_VEC)
    ) slot_i (
      .clk(clk), .rst(rst),
      .req_valid_i(req_valid_i), .req_bank_i(req_bank_i),
      .unlock_i(unlock_i), .unlock_bank_i(unlock_bank_i),
      .held_d_o(held_d[b]), .owner_d_o(owner_d[b])
    );
  end

  always_comb begin
    logic [BANK_W-1:0] bsel;
    for (int i = 0; i < N_REQ; i++) begin
      bsel = req_bank_i[i*BANK_W +: BANK_W];
      grant_d[i] = req_valid_i[i] && held_d[bsel] && (owner_d[bsel] == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      wait_o  <= '0;
    end else begin
      grant_o <= grant_d;
      wait_o  <= req_valid_i & ~grant_d;
    end
  end
endmodule

// File: rtl/bank_lock_checker.sv
module bank_lock_checker #(
  parameter int N_REQ  = 10,
  parameter int BANK_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_REQ-1:0]        req_valid_i,
  input logic [N_REQ*BANK_W-1:0] req_bank_i,
  input logic [N_REQ-1:0]        unlock_i,
  input logic [N_REQ*BANK_W-1:0] unlock_bank_i,
  input logic [N_REQ-1:0]        grant_o,
  input logic [N_REQ-1:0]        wait_o
);
  logic [N_REQ-1:0]        rv_q;
  logic [N_REQ*BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q   <= '0;
      bank_q <= '0;
    end else begin
      rv_q   <= req_valid_i;
      bank_q <= req_bank_i;
    end
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    AST_GRANT_WAIT_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(grant_o[i] && wait_o[i])); // R4
    AST_OUT_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
      (grant_o[i] || wait_o[i]) == rv_q[i]); // R4
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
      (grant_o[i] && req_valid_i[i] &&
       req_bank_i[i*BANK_W +: BANK_W] == bank_q[i*BANK_W +: BANK_W] &&
       !(unlock_i[i] && unlock_bank_i[i*BANK_W +: BANK_W] == bank_q[i*BANK_W +: BANK_W]))
      |=> grant_o[i]); // R8
    for (genvar j = i + 1; j < N_REQ; j++) begin : g_pair
      AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (grant_o[i] && grant_o[j]) |->
        (bank_q[i*BANK_W +: BANK_W] != bank_q[j*BANK_W +: BANK_W])); // R2
    end
  end
endmodule

bind bank_lock_arbiter bank_lock_checker #(.N_REQ(N_REQ), .BANK_W(BANK_W)) chk_i (.*);

// File: tb/bank_lock_arbiter_tb_top.sv
module bank_lock_arbiter_tb_top;
  localparam int NR = 10;
  localparam int NB = 16;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NR-1:0]    rv = '0;
  logic [NR-1:0]    ul = '0;
  logic [BW-1:0]    bk  [NR];
  logic [BW-1:0]    ubk [NR];
  logic [NR*BW-1:0] bk_flat, ubk_flat;
  logic [NR-1:0]    grant_o, wait_o;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      bk_flat[i*BW +: BW]  = bk[i];
      ubk_flat[i*BW +: BW] = ubk[i];
    end
  end

  bank_lock_arbiter dut_i (
    .clk(clk), .rst(rst),
    .req_valid_i(rv), .req_bank_i(bk_flat),
    .unlock_i(ul), .unlock_bank_i(ubk_flat),
    .grant_o(grant_o), .wait_o(wait_o)
  );

  // Reference model state
  int prio [NR] = '{0, 1, 2, 3, 4, 5, 6, 7, -2, 3};
  int own [NB];
  bit eg [NR];
  bit ew [NR];
  int n_chk = 0;
  int n_fail = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic model_edge();
    for (int b = 0; b < NB; b++) begin
      bit rel;
      rel = (own[b] >= 0) && ul[own[b]] && (int'(ubk[own[b]]) == b);
      if (own[b] < 0 || rel) begin
        int best;
        best = -1;
        for (int i = 0; i < NR; i++)
          if (rv[i] && int'(bk[i]) == b && (best < 0 || prio[i] > prio[best]))
            best = i;
        own[b] = best;
      end
    end
    for (int i = 0; i < NR; i++) begin
      eg[i] = rv[i] && (own[bk[i]] == i);
      ew[i] = rv[i] && !eg[i];
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      n_chk++;
      if (grant_o[i] !== eg[i] || wait_o[i] !== ew[i]) begin
        n_fail++;
        $display("FAIL %s model req%0d: grant/wait = %b/%b, expected %b/%b",
                 tag, i, grant_o[i], wait_o[i], eg[i], ew[i]);
      end
    end
    ul = '0;
  endtask

  task automatic expect_gw(input int i, input bit g, input bit w, input string tag);
    n_chk++;
    if (grant_o[i] !== g || wait_o[i] !== w) begin
      n_fail++;
      $display("FAIL %s req%0d: grant/wait = %b/%b, expected %b/%b",
               tag, i, grant_o[i], wait_o[i], g, w);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin bk[i] = '0; ubk[i] = '0; end
    for (int b = 0; b < NB; b++) own[b] = -1;
    for (int i = 0; i < NR; i++) begin eg[i] = 0; ew[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NR; i++) expect_gw(i, 0, 0, "R1");
    rst = 1'b0;
    step("R1");
    for (int i = 0; i < NR; i++) expect_gw(i, 0, 0, "R1");

    // Contention on bank 5
    rv[2] = 1; bk[2] = 5; step("R3");
    expect_gw(2, 1, 0, "R3");
    rv[6] = 1; bk[6] = 5; step("R8");
    expect_gw(6, 0, 1, "R8"); expect_gw(2, 1, 0, "R8");
    rv[4] = 1; bk[4] = 5; rv[9] = 1; bk[9] = 5; rv[8] = 1; bk[8] = 5;
    ul[6] = 1; ubk[6] = 5; step("R9");
    expect_gw(2, 1, 0, "R9"); expect_gw(6, 0, 1, "R9"); expect_gw(4, 0, 1, "R4");
    ul[2] = 1; ubk[2] = 5; rv[2] = 0; step("R7");
    expect_gw(6, 1, 0, "R7"); expect_gw(2, 0, 0, "R4");
    ul[6] = 1; ubk[6] = 5; rv[6] = 0; step("R5");
    expect_gw(4, 1, 0, "R5");
    ul[4] = 1; ubk[4] = 5; rv[4] = 0; step("R5");
    expect_gw(9, 1, 0, "R5"); expect_gw(8, 0, 1, "R5");
    ul[9] = 1; ubk[9] = 5; rv[9] = 0; step("R5");
    expect_gw(8, 1, 0, "R5");
    ul[8] = 1; ubk[8] = 5; rv[8] = 0; step("R5");

    // Equal priority tie on bank 1
    rv[0] = 1; bk[0] = 1; step("R3");
    rv[9] = 1; bk[9] = 1; rv[3] = 1; bk[3] = 1; step("R6");
    ul[0] = 1; ubk[0] = 1; rv[0] = 0; step("R6");
    expect_gw(3, 1, 0, "R6"); expect_gw(9, 0, 1, "R6");
    ul[3] = 1; ubk[3] = 1; rv[3] = 0; step("R6");
    expect_gw(9, 1, 0, "R6");
    ul[9] = 1; ubk[9] = 1; rv[9] = 0; step("R6");

    // Independent banks and multiple ownership
    rv[0] = 1; bk[0] = 7; rv[1] = 1; bk[1] = 8; step("R10");
    expect_gw(0, 1, 0, "R10"); expect_gw(1, 1, 0, "R10");
    bk[0] = 9; step("R10");
    expect_gw(0, 1, 0, "R10");
    rv[5] = 1; bk[5] = 7; step("R10");
    expect_gw(5, 0, 1, "R10");
    bk[0] = 7; step("R11");
    expect_gw(0, 1, 0, "R11"); expect_gw(5, 0, 1, "R11");
    ul[0] = 1; ubk[0] = 7; rv[0] = 0; step("R10");
    expect_gw(5, 1, 0, "R10");
    rv[2] = 1; bk[2] = 9; step("R10");
    expect_gw(2, 0, 1, "R10");
    ul[0] = 1; ubk[0] = 9; step("R7");
    expect_gw(2, 1, 0, "R7");

    // Random crowding on three banks
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < NR; i++) begin
        rv[i]  = ($urandom % 4) != 0;
        bk[i]  = BW'($urandom % 3);
        ul[i]  = ($urandom % 3) == 0;
        ubk[i] = BW'($urandom % 3);
      end
      step("R2");
    end

    summary();
    $finish;
  end
endmodule